// File: doc/BRIEF.md
# Indexed Block Configuration Register Target

This block is a two-wire serial bus target that holds a 24-byte configuration register file for a clock-generation subsystem. It does not move one register per transfer. The host names a starting index and then streams a block of bytes. On writes, the host also sends a byte count that limits how many data bytes are accepted. On reads, the target first returns a count byte taken from a programmable register, and then returns the data bytes.

The bus pins are oversampled by the system clock. The open-drain data line is modelled as a pull-low enable. The stored configuration is presented as one flat parallel vector. A derived divider word follows the programmed divider registers only while a programming-enable bit is set; otherwise it holds the power-up divider setting. Some locations show read-only inputs (strap levels, an alarm flag, a revision nibble) or a fixed device identifier.

Top module: `cfg_i2c_target`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address is not acknowledged, and every following byte is neither acknowledged nor stored until the next START.
- R2: A write is the address 0xD2, a starting index N, a byte count X, and then data bytes. The data bytes go to N, N+1, and so on. Every byte up to and including the X-th data byte is acknowledged.
- R3: Data bytes after the X-th are not acknowledged and are not stored. With X = 0, the first data byte is not acknowledged.
- R4: A read is 0xD2, N, a repeated START, and then 0xD3. The target then sends the value of register 8 first, followed by the bytes from index N upward, one per acknowledged byte. Register 8 is writable and resets to 0x0F.
- R5: A read at any index of 24 or above returns 0x00.
- R6: Writable bits per register: 0xFF at 0–3, 8, 9, 11–13 and 15–22; 0xDF at 10; 0x1F at 14; 0x0F at 23; none at 4–7. A write leaves every non-writable bit unchanged.
- R7: The read view shows fixed or external values at these places:
  - register 4 reads {strap_i, 4'h0};
  - register 5 reads 0x00;
  - register 6 reads {rev_id_i, 4'h1};
  - register 7 reads 0x3C;
  - bit 5 of register 10 reads alarm_i.
- R8: After reset, registers 1, 2, 3, 8, 9, 15, 16 and 17 hold 0xF7, 0xFF, 0x7F, 0x0F, 0x10, 0x55, 0x55 and 0x09. All other registers hold 0x00.
- R9: eff_div_o equals {reg17, reg16, reg15} while bit 7 of register 10 is 1. Otherwise it equals 0x095555.
- R10: After the host does not acknowledge a read byte, the target stops driving SDA until the next START.
- R11: A STOP ends any transfer. A START at any point begins a new address phase.
- R12: The target changes its SDA drive only while SCL is low.
- R13: cfg_o carries register k in bits [8k+7:8k] and holds only the stored writable bits. Non-writable positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 4 | Latched strap levels shown in register 4 |
| alarm_i | input | 1 | Alarm flag shown in register 10 bit 5 |
| rev_id_i | input | 4 | Revision nibble shown in register 6 |
| cfg_o | output | 192 | Flat stored register contents |
| eff_div_o | output | 24 | Effective divider word |

## Verification
The assertions check several properties on every cycle:
- the SDA drive rises only while the synchronised SCL is low;
- a START releases SDA and restarts the address phase;
- a STOP returns the sequencer to idle;
- no write strobe appears inside a read transfer;
- a write to a location with no writable bits leaves the register file unchanged;
- stored state changes only right after a write strobe.

Only the bench scenarios can show the rest. These are the byte ordering of block transfers, the count byte at the head of a read, the enforcement of the write byte count, the zeros returned past the last register, the read-only views, and the switching of the divider word by the programming-enable bit. The bench sweeps a one-byte write over every index and then reads all locations back.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } bus_st_e;

   typedef enum logic [1:0] {
      RL_ADDR,
      RL_INDEX,
      RL_COUNT,
      RL_DATA
   } rx_role_e;

   localparam int IDX_STRAP  = 4;
   localparam int IDX_VID    = 6;
   localparam int IDX_DID    = 7;
   localparam int IDX_CNT    = 8;
   localparam int IDX_CTRL   = 10;
   localparam int IDX_DIV    = 15;
   localparam int ALARM_BIT  = 5;
   localparam int PROG_BIT   = 7;
   localparam logic [3:0] VENDOR_NIB = 4'h1;

   // writable bit mask per location
   function automatic logic [7:0] wr_mask(input int unsigned idx);
      logic [7:0] m;
      m = 8'h00;
      if (idx <= 3 || idx == 8 || idx == 9) m = 8'hFF;
      else if (idx >= 11 && idx <= 13)      m = 8'hFF;
      else if (idx >= 15 && idx <= 22)      m = 8'hFF;
      else if (idx == 10)                   m = 8'hDF;
      else if (idx == 14)                   m = 8'h1F;
      else if (idx == 23)                   m = 8'h0F;
      return m;
   endfunction

   // power-up contents per location
   function automatic logic [7:0] reset_val(input int unsigned idx);
      logic [7:0] v;
      case (idx)
         1:       v = 8'hF7;
         2:       v = 8'hFF;
         3:       v = 8'h7F;
         8:       v = 8'h0F;
         9:       v = 8'h10;
         15, 16:  v = 8'h55;
         17:      v = 8'h09;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
   parameter int STAGES = 2,
   parameter bit FILTER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgi2c_sync: STAGES must be at least 2");
   end
   if (FILTER && STAGES < 3) begin : g_bad_filter
      $error("cfgi2c_sync: FILTER needs STAGES of 3 or more");
   end

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      end
   end

   if (FILTER) begin : g_majority
      logic [2:0] sw, dw;
      assign sw      = scl_sh[STAGES-1 -: 3];
      assign dw      = sda_sh[STAGES-1 -: 3];
      assign scl_lvl = (sw[0] & sw[1]) | (sw[0] & sw[2]) | (sw[1] & sw[2]);
      assign sda_lvl = (dw[0] & dw[1]) | (dw[0] & dw[2]) | (dw[1] & dw[2]);
   end else begin : g_plain
      assign scl_lvl = scl_sh[STAGES-1];
      assign sda_lvl = sda_sh[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0] ADDR7 = 7'h69
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_lvl,
   input  logic       sda_lvl,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] rd_data,
   input  logic [7:0] cnt_byte,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_data,
   output logic [7:0] rd_idx
);

   bus_st_e    st;
   rx_role_e   role;
   logic [7:0] shreg;
   logic [3:0] bitcnt;
   logic [7:0] idx;
   logic [7:0] wcnt;
   logic       rd_mode;

   assign rd_idx = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         role    <= RL_ADDR;
         shreg   <= '0;
         bitcnt  <= '0;
         idx     <= '0;
         wcnt    <= '0;
         rd_mode <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st     <= ST_RX;
            role   <= RL_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     case (role)
                        RL_ADDR: begin
                           if (shreg[7:1] == ADDR7) begin
                              sda_oe  <= 1'b1;
                              rd_mode <= shreg[0];
                              role    <= RL_INDEX;
                              st      <= ST_RX_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        RL_INDEX: begin
                           idx    <= shreg;
                           sda_oe <= 1'b1;
                           role   <= RL_COUNT;
                           st     <= ST_RX_ACK;
                        end
                        RL_COUNT: begin
                           wcnt   <= shreg;
                           sda_oe <= 1'b1;
                           role   <= RL_DATA;
                           st     <= ST_RX_ACK;
                        end
                        default: begin
                           if (wcnt != 8'd0) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= idx;
                              wr_data <= shreg;
                              idx     <= idx + 8'd1;
                              wcnt    <= wcnt - 8'd1;
                              sda_oe  <= 1'b1;
                              st      <= ST_RX_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rd_mode && role == RL_INDEX) begin
                        shreg  <= cnt_byte;
                        sda_oe <= ~cnt_byte[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     st     <= ST_TX_ACK;
                  end else if (scl_fall && bitcnt != 4'd0) begin
                     sda_oe <= ~shreg[6];
                     shreg  <= {shreg[6:0], 1'b0};
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise && sda_lvl) begin
                     st <= ST_IDLE;
                  end else if (scl_fall) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     idx    <= idx + 8'd1;
                     bitcnt <= '0;
                     st     <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R11
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && st == ST_RX && bitcnt == 4'd0));

   // R11
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE && !sda_oe));

   // R10
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R4
   no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_mode);

endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
   import cfgi2c_pkg::*;
#(
   parameter int         NREG   = 24,
   parameter logic [7:0] DEV_ID = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_idx,
   input  logic [3:0]        strap_i,
   input  logic              alarm_i,
   input  logic [3:0]        rev_id_i,
   output logic [7:0]        rd_data,
   output logic [7:0]        cnt_byte,
   output logic [NREG*8-1:0] cfg_flat,
   output logic [23:0]       eff_div
);

   localparam int         IW      = $clog2(NREG);
   localparam logic [7:0] NREG8   = 8'(NREG);
   localparam logic [23:0] DIV_DEF = {reset_val(IDX_DIV + 2), reset_val(IDX_DIV + 1),
                                      reset_val(IDX_DIV)};

   logic [NREG*8-1:0] view_flat;

   for (genvar g = 0; g < NREG; g++) begin : g_loc
      localparam logic [7:0] MASK = wr_mask(g);
      localparam logic [7:0] INIT = reset_val(g) & wr_mask(g);
      logic [7:0] q;

      if (MASK == 8'h00) begin : g_const
         assign q = 8'h00;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= INIT;
            else if (wr_en && wr_idx == 8'(g))   q <= wr_data & MASK;
         end
      end

      assign cfg_flat[g*8 +: 8] = q;

      if (g == IDX_STRAP) begin : g_v_strap
         assign view_flat[g*8 +: 8] = {strap_i, 4'h0};
      end else if (g == IDX_VID) begin : g_v_vid
         assign view_flat[g*8 +: 8] = {rev_id_i, VENDOR_NIB};
      end else if (g == IDX_DID) begin : g_v_did
         assign view_flat[g*8 +: 8] = DEV_ID;
      end else if (g == IDX_CTRL) begin : g_v_ctrl
         assign view_flat[g*8 +: 8] = {q[7:ALARM_BIT+1], alarm_i, q[ALARM_BIT-1:0]};
      end else begin : g_v_plain
         assign view_flat[g*8 +: 8] = q;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_idx < NREG8) rd_data = view_flat[{rd_idx[IW-1:0], 3'b000} +: 8];
   end

   assign cnt_byte = cfg_flat[IDX_CNT*8 +: 8];
   assign eff_div  = cfg_flat[IDX_CTRL*8 + PROG_BIT] ? cfg_flat[IDX_DIV*8 +: 24] : DIV_DEF;

   // R6
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= NREG8 || wr_mask(int'(wr_idx)) == 8'h00)) |=> $stable(cfg_flat));

   // R13
   change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat) |-> $past(wr_en));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
   parameter int         NREG          = 24,
   parameter logic [6:0] ADDR7         = 7'h69,
   parameter logic [7:0] DEV_ID        = 8'h3C,
   parameter int         SYNC_STAGES   = 2,
   parameter bit         GLITCH_FILTER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [3:0]        strap_i,
   input  logic              alarm_i,
   input  logic [3:0]        rev_id_i,
   output logic [NREG*8-1:0] cfg_o,
   output logic [23:0]       eff_div_o
);

   if (NREG < 18 || NREG > 255) begin : g_bad_nreg
      $error("cfg_i2c_target: NREG must lie in 18..255");
   end

   logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_en;
   logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_byte;

   cfgi2c_sync #(
      .STAGES (SYNC_STAGES),
      .FILTER (GLITCH_FILTER)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   cfgi2c_proto #(
      .ADDR7 (ADDR7)
   ) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .cnt_byte  (cnt_byte),
      .sda_oe    (sda_oe_o),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx)
   );

   cfgi2c_regs #(
      .NREG   (NREG),
      .DEV_ID (DEV_ID)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .strap_i  (strap_i),
      .alarm_i  (alarm_i),
      .rev_id_i (rev_id_i),
      .rd_data  (rd_data),
      .cnt_byte (cnt_byte),
      .cfg_flat (cfg_o),
      .eff_div  (eff_div_o)
   );

endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;

   localparam int NREG = 24;
   localparam int Q    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_line;
   assign sda_line = ~(m_low | sda_oe);

   logic [3:0]        strap = 4'hA;
   logic              alarm = 1'b0;
   logic [3:0]        rev   = 4'h5;
   logic [NREG*8-1:0] cfg;
   logic [23:0]       eff_div;

   cfg_i2c_target u_cfg_i2c_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_oe_o  (sda_oe),
      .strap_i   (strap),
      .alarm_i   (alarm),
      .rev_id_i  (rev),
      .cfg_o     (cfg),
      .eff_div_o (eff_div)
   );

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] shadow [0:NREG-1];
   logic [7:0] wbuf   [0:31];
   logic       wack   [0:31];
   logic [7:0] rbuf   [0:31];
   logic       ack_a, ack_i, ack_c;
   logic [7:0] cnt_rx;
   logic       tail_bit;
   int         edge_viol = 0;
   logic       prev_oe = 1'b0;

   always @(negedge clk) begin
      if (sda_oe !== prev_oe && scl) edge_viol++;
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] bmask(input int i);
      if (i <= 3 || i == 8 || i == 9 || (i >= 11 && i <= 13) || (i >= 15 && i <= 22)) return 8'hFF;
      if (i == 10) return 8'hDF;
      if (i == 14) return 8'h1F;
      if (i == 23) return 8'h0F;
      return 8'h00;
   endfunction

   function automatic logic [7:0] breset(input int i);
      case (i)
         1: return 8'hF7;
         2: return 8'hFF;
         3: return 8'h7F;
         8: return 8'h0F;
         9: return 8'h10;
         15, 16: return 8'h55;
         17: return 8'h09;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_view(input int i);
      if (i >= NREG) return 8'h00;
      case (i)
         4: return {strap, 4'h0};
         5: return 8'h00;
         6: return {rev, 4'h1};
         7: return 8'h3C;
         10: return shadow[10] | {2'b00, alarm, 5'b00000};
         default: return shadow[i];
      endcase
   endfunction

   function automatic logic [23:0] exp_div();
      if (shadow[10][7]) return {shadow[17], shadow[16], shadow[15]};
      return 24'h095555;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; hold();
      scl = 1'b1;   hold();
      m_low = 1'b1; hold();
      scl = 1'b0;   hold();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; hold();
      scl = 1'b1;   hold();
      m_low = 1'b0; hold();
   endtask

   task automatic put_bit(input logic b);
      hold();
      m_low = ~b; hold();
      scl = 1'b1; hold(); hold();
      scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      hold();
      m_low = 1'b0; hold();
      scl = 1'b1; hold();
      b = sda_line; hold();
      scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(input logic ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic wr_txn(input logic [7:0] n, input logic [7:0] x, input int ns);
      bus_start();
      send_byte(8'hD2, ack_a);
      send_byte(n, ack_i);
      send_byte(x, ack_c);
      for (int i = 0; i < ns; i++) send_byte(wbuf[i], wack[i]);
      bus_stop();
      for (int i = 0; i < ns && i < int'(x); i++)
         if (int'(n) + i < NREG) shadow[int'(n) + i] = wbuf[i] & bmask(int'(n) + i);
   endtask

   task automatic rd_txn(input logic [7:0] n, input int nb);
      bus_start();
      send_byte(8'hD2, ack_a);
      send_byte(n, ack_i);
      bus_start();
      send_byte(8'hD3, ack_c);
      recv_byte(1'b1, cnt_rx);
      for (int i = 0; i < nb; i++) recv_byte(i != nb - 1, rbuf[i]);
      get_bit(tail_bit);
      bus_stop();
   endtask

   task automatic check_cfg(input string req);
      for (int i = 0; i < NREG; i++) check(req, {24'h0, cfg[i*8 +: 8]}, {24'h0, shadow[i]});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic a;
      for (int i = 0; i < NREG; i++) shadow[i] = breset(i) & bmask(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R8 R13: reset contents
      check_cfg("R8");
      check("R12 idle drive", {31'h0, sda_oe}, 32'h0);
      // R9: default divider word
      check("R9 default", {8'h0, eff_div}, {8'h0, exp_div()});

      // R1: foreign addresses are ignored
      for (int k = 0; k < 4; k++) begin
         logic [7:0] bad;
         bad = (k == 0) ? 8'hA0 : (k == 1) ? 8'hD0 : (k == 2) ? 8'hD4 : 8'h52;
         bus_start();
         send_byte(bad, a);
         check("R1 addr nack", {31'h0, a}, 32'h0);
         send_byte(8'h00, a);
         check("R1 follow nack", {31'h0, a}, 32'h0);
         send_byte(8'h01, a);
         send_byte(8'h5A, a);
         check("R1 data nack", {31'h0, a}, 32'h0);
         bus_stop();
      end
      check_cfg("R1 no store");

      // R2 R6: one-byte write sweep over every index
      for (int n = 0; n < NREG; n++) begin
         wbuf[0] = 8'(n * 37 + 90);
         wr_txn(8'(n), 8'd1, 1);
         check("R2 addr ack", {31'h0, ack_a}, 32'h1);
         check("R2 data ack", {31'h0, wack[0]}, 32'h1);
      end
      check_cfg("R6 masks");
      check("R9 sweep", {8'h0, eff_div}, {8'h0, exp_div()});

      // R4 R5 R7: read every location back, plus two past the end
      rd_txn(8'd0, NREG + 2);
      check("R4 read addr ack", {31'h0, ack_c}, 32'h1);
      check("R4 count byte", {24'h0, cnt_rx}, {24'h0, shadow[8]});
      for (int i = 0; i < NREG + 2; i++) check("R4 R7 view", {24'h0, rbuf[i]}, {24'h0, exp_view(i)});
      check("R10 release", {31'h0, tail_bit}, 32'h1);

      // R2: multi-byte write across mixed masks
      for (int i = 0; i < 6; i++) wbuf[i] = 8'hF0 | 8'(i);
      wr_txn(8'd12, 8'd6, 6);
      for (int i = 0; i < 6; i++) check("R2 block ack", {31'h0, wack[i]}, 32'h1);
      check_cfg("R2 block");

      // R3: bytes past the count are refused
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h30 + 8'(i);
      wr_txn(8'd0, 8'd2, 4);
      check("R3 in count", {31'h0, wack[1]}, 32'h1);
      check("R3 over count", {31'h0, wack[2]}, 32'h0);
      check("R3 over count2", {31'h0, wack[3]}, 32'h0);
      check_cfg("R3 store");
      wbuf[0] = 8'hEE;
      wr_txn(8'd9, 8'd0, 1);
      check("R3 zero count", {31'h0, wack[0]}, 32'h0);
      check("R3 zero store", {24'h0, cfg[9*8 +: 8]}, {24'h0, shadow[9]});

      // R4 R5: programmable count and reads past the end
      wbuf[0] = 8'h05;
      wr_txn(8'd8, 8'd1, 1);
      rd_txn(8'd20, 6);
      check("R4 new count", {24'h0, cnt_rx}, 32'h05);
      for (int i = 0; i < 6; i++) check("R5 tail read", {24'h0, rbuf[i]}, {24'h0, exp_view(20 + i)});

      // R7: external read-only values follow inputs
      strap = 4'h3; alarm = 1'b1; rev = 4'h9;
      rd_txn(8'd4, 7);
      for (int i = 0; i < 7; i++) check("R7 inputs", {24'h0, rbuf[i]}, {24'h0, exp_view(4 + i)});
      check("R10 release2", {31'h0, tail_bit}, 32'h1);

      // R9: programming-enable gates the divider word
      wbuf[0] = 8'h00;
      wr_txn(8'd10, 8'd1, 1);
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_txn(8'd15, 8'd3, 3);
      check("R9 gated", {8'h0, eff_div}, 32'h095555);
      wbuf[0] = 8'h80;
      wr_txn(8'd10, 8'd1, 1);
      check("R9 enabled", {8'h0, eff_div}, 32'h332211);

      // R11: STOP mid-write, START mid-write
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd2, a); send_byte(8'd3, a);
      send_byte(8'h11, a);
      bus_stop();
      shadow[2] = 8'h11;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd3, a);
      bus_start();
      send_byte(8'hD2, a);
      check("R11 restart ack", {31'h0, a}, 32'h1);
      send_byte(8'd11, a); send_byte(8'd1, a); send_byte(8'h66, a);
      bus_stop();
      shadow[11] = 8'h66;
      check_cfg("R11 framing");

      // R12: drive changes only with SCL low
      check("R12 edge", edge_viol, 0);

      finish_run();
   end

endmodule